// File: doc/BRIEF.md
# Wide instruction stream assembler

This block sits between an instruction fetch path and a decoder. It takes a stream of 64-bit instruction slots over a valid/ready handshake and splits each slot into its fields. Most instructions fill one slot. The 64-bit immediate load fills two consecutive slots, and the block merges them into one output instruction that carries the full 64-bit immediate. For this reason the output rate is not fixed at one instruction per input slot.

The block holds the first slot of a wide instruction until the next slot arrives. A stream that ends between the two halves is reported as a truncation. An opcode that uses the immediate mode but is not the wide load is flagged as illegal and still passes through as a single slot. All results leave through one output register that honours downstream backpressure.

Top module: `wide_slot_asm`

## Requirements
- R1: A single-slot instruction is split as opcode = bits [7:0], destination = [11:8], source = [15:12], offset = [31:16], immediate = [63:32]. It appears on the output one cycle after the slot is accepted.
- R2: A slot whose opcode is 0x18 (mode bits [7:5] = 0, size bits [4:3] = double word, class bits [2:0] = load) and whose last flag is low starts a wide instruction. No output follows it. One cycle after the next slot is accepted, a single output appears with the wide flag set, the fields of the first slot, and the second slot as the 64-bit immediate.
- R3: Every output that is not wide has its wide flag at 0 and its 64-bit immediate at 0.
- R4: An opcode with mode bits [7:5] = 0 that is not 0x18 is output as a single slot with the illegal flag set. Every other single-slot output has the illegal flag at 0.
- R5: A slot with opcode 0x18 and the last flag high raises trunc_err_o for one cycle, on the cycle after it is accepted. It produces no output, and the next slot is decoded as a first slot.
- R6: While an output is valid and ins_ready_i is low, slot_ready_o is low and the output fields stay stable.
- R7: Every instruction is output exactly once, in stream order, under any pattern of input gaps and output backpressure.
- R8: Reset clears the output valid flag, the truncation flag and any half-received wide instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| slot_valid_i | input | 1 | Input slot valid |
| slot_data_i | input | 64 | Input slot |
| slot_last_i | input | 1 | Slot is the last one of the stream |
| slot_ready_o | output | 1 | Block can accept a slot |
| ins_valid_o | output | 1 | Output instruction valid |
| ins_ready_i | input | 1 | Downstream accepts the instruction |
| ins_opcode_o | output | 8 | Opcode |
| ins_dst_o | output | 4 | Destination register index |
| ins_src_o | output | 4 | Source register index |
| ins_off_o | output | 16 | Signed offset |
| ins_imm_o | output | 32 | 32-bit immediate |
| ins_wide_o | output | 1 | Instruction was assembled from two slots |
| ins_imm64_o | output | 64 | 64-bit immediate of a wide instruction |
| ins_illegal_o | output | 1 | Immediate mode with an opcode other than 0x18 |
| trunc_err_o | output | 1 | One-cycle pulse: wide instruction cut off by end of stream |

## Verification
A single-slot instruction is due one edge after its slot is accepted. A wide instruction is due one edge after its second slot is accepted, and a truncation pulse is due one edge after the offending slot. The bench drives at the falling edge and samples a quarter period later. It keeps a model queue that is filled at each accepting edge and drained at each output handshake, so every result is compared in the cycle it becomes visible. A stalled output is saved and compared again in the next cycle.

// File: rtl/wsa_pkg.sv
package wsa_pkg;
  localparam int unsigned SLOT_W = 64;
  localparam int unsigned OP_W   = 8;
  localparam int unsigned REG_W  = 4;
  localparam int unsigned OFF_W  = 16;
  localparam int unsigned IMM_W  = 32;
  localparam int unsigned MODE_W = 3;
  localparam logic [MODE_W-1:0] MODE_IMM     = '0;
  localparam logic [OP_W-1:0]   OP_LD_DW_IMM = 8'h18;

  // packed order matches slot layout, MSB first
  typedef struct packed {
    logic [IMM_W-1:0] imm;
    logic [OFF_W-1:0] off;
    logic [REG_W-1:0] src;
    logic [REG_W-1:0] dst;
    logic [OP_W-1:0]  op;
  } insn_t;

  typedef struct packed {
    insn_t             f;
    logic              wide;
    logic              illegal;
    logic [SLOT_W-1:0] imm64;
  } out_t;
endpackage

// File: rtl/wsa_decode.sv
module wsa_decode
  import wsa_pkg::*;
(
  input  logic [SLOT_W-1:0] slot_i,
  output insn_t             insn_o,
  output logic              wide_o,
  output logic              illegal_o
);
  assign insn_o    = insn_t'(slot_i);
  assign wide_o    = (insn_o.op == OP_LD_DW_IMM);
  assign illegal_o = (insn_o.op[OP_W-1 -: MODE_W] == MODE_IMM) && !wide_o;
endmodule

// File: rtl/wsa_pair.sv
module wsa_pair
  import wsa_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              accept_i,
  input  logic              last_i,
  input  logic [SLOT_W-1:0] slot_i,
  input  insn_t             insn_i,
  input  logic              wide_i,
  input  logic              illegal_i,
  output logic              emit_o,
  output out_t              out_o,
  output logic              trunc_o
);
  logic  waiting_q;
  insn_t held_q;
  logic  trunc_q;
  logic  first_wide;

  assign first_wide = accept_i && !waiting_q && wide_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      waiting_q <= 1'b0;
      held_q    <= '0;
      trunc_q   <= 1'b0;
    end else begin
      trunc_q <= first_wide && last_i;
      if (accept_i) waiting_q <= first_wide && !last_i;
      if (first_wide && !last_i) held_q <= insn_i;
    end
  end

  // second half of a pair, or any non-wide first slot
  assign emit_o  = accept_i && (waiting_q || !wide_i);
  assign trunc_o = trunc_q;

  always_comb begin
    if (waiting_q) begin
      out_o.f       = held_q;
      out_o.wide    = 1'b1;
      out_o.illegal = 1'b0;
      out_o.imm64   = slot_i;
    end else begin
      out_o.f       = insn_i;
      out_o.wide    = 1'b0;
      out_o.illegal = illegal_i;
      out_o.imm64   = '0;
    end
  end
endmodule

// File: rtl/wsa_out_reg.sv
module wsa_out_reg
  import wsa_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  out_t data_i,
  input  logic ready_i,
  output logic valid_o,
  output out_t data_o,
  output logic free_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      data_o  <= '0;
    end else if (load_i) begin
      valid_o <= 1'b1;
      data_o  <= data_i;
    end else if (ready_i) begin
      valid_o <= 1'b0;
    end
  end

  assign free_o = !valid_o || ready_i;
endmodule

// File: rtl/wide_slot_asm.sv
module wide_slot_asm
  import wsa_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              slot_valid_i,
  input  logic [SLOT_W-1:0] slot_data_i,
  input  logic              slot_last_i,
  output logic              slot_ready_o,
  output logic              ins_valid_o,
  input  logic              ins_ready_i,
  output logic [OP_W-1:0]   ins_opcode_o,
  output logic [REG_W-1:0]  ins_dst_o,
  output logic [REG_W-1:0]  ins_src_o,
  output logic [OFF_W-1:0]  ins_off_o,
  output logic [IMM_W-1:0]  ins_imm_o,
  output logic              ins_wide_o,
  output logic [SLOT_W-1:0] ins_imm64_o,
  output logic              ins_illegal_o,
  output logic              trunc_err_o
);
  insn_t dec_insn;
  logic  dec_wide, dec_illegal;
  logic  accept, emit, free;
  out_t  pair_out, reg_out;

  assign accept = slot_valid_i && free;

  wsa_decode u_dec (
    .slot_i    (slot_data_i),
    .insn_o    (dec_insn),
    .wide_o    (dec_wide),
    .illegal_o (dec_illegal)
  );

  wsa_pair u_pair (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .accept_i  (accept),
    .last_i    (slot_last_i),
    .slot_i    (slot_data_i),
    .insn_i    (dec_insn),
    .wide_i    (dec_wide),
    .illegal_i (dec_illegal),
    .emit_o    (emit),
    .out_o     (pair_out),
    .trunc_o   (trunc_err_o)
  );

  wsa_out_reg u_out (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (emit),
    .data_i  (pair_out),
    .ready_i (ins_ready_i),
    .valid_o (ins_valid_o),
    .data_o  (reg_out),
    .free_o  (free)
  );

  assign slot_ready_o  = free;
  assign ins_opcode_o  = reg_out.f.op;
  assign ins_dst_o     = reg_out.f.dst;
  assign ins_src_o     = reg_out.f.src;
  assign ins_off_o     = reg_out.f.off;
  assign ins_imm_o     = reg_out.f.imm;
  assign ins_wide_o    = reg_out.wide;
  assign ins_imm64_o   = reg_out.imm64;
  assign ins_illegal_o = reg_out.illegal;
endmodule

// File: rtl/wsa_checker.sv
module wsa_checker
  import wsa_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              slot_ready_o,
  input logic              ins_valid_o,
  input logic              ins_ready_i,
  input logic [OP_W-1:0]   ins_opcode_o,
  input logic [IMM_W-1:0]  ins_imm_o,
  input logic              ins_wide_o,
  input logic [SLOT_W-1:0] ins_imm64_o,
  input logic              ins_illegal_o
);
  a_r6_hold_under_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ins_valid_o && !ins_ready_i |=> ins_valid_o && $stable(ins_opcode_o)
      && $stable(ins_imm_o) && $stable(ins_imm64_o) && $stable(ins_wide_o));

  a_r6_input_blocked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ins_valid_o && !ins_ready_i |-> !slot_ready_o);

  a_r2_wide_opcode: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ins_valid_o && ins_wide_o |-> ins_opcode_o == OP_LD_DW_IMM && !ins_illegal_o);

  a_r3_narrow_imm64_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ins_valid_o && !ins_wide_o |-> ins_imm64_o == '0);

  a_r4_illegal_mode: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ins_valid_o && ins_illegal_o |->
      ins_opcode_o[OP_W-1 -: MODE_W] == MODE_IMM && ins_opcode_o != OP_LD_DW_IMM);
endmodule

bind wide_slot_asm wsa_checker chk_i (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .slot_ready_o  (slot_ready_o),
  .ins_valid_o   (ins_valid_o),
  .ins_ready_i   (ins_ready_i),
  .ins_opcode_o  (ins_opcode_o),
  .ins_imm_o     (ins_imm_o),
  .ins_wide_o    (ins_wide_o),
  .ins_imm64_o   (ins_imm64_o),
  .ins_illegal_o (ins_illegal_o)
);

// File: tb/wide_slot_asm_tb_top.sv
module wide_slot_asm_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        slot_valid_i = 1'b0;
  logic [63:0] slot_data_i = '0;
  logic        slot_last_i = 1'b0;
  logic        slot_ready_o;
  logic        ins_valid_o;
  logic        ins_ready_i = 1'b0;
  logic [7:0]  ins_opcode_o;
  logic [3:0]  ins_dst_o, ins_src_o;
  logic [15:0] ins_off_o;
  logic [31:0] ins_imm_o;
  logic        ins_wide_o;
  logic [63:0] ins_imm64_o;
  logic        ins_illegal_o;
  logic        trunc_err_o;

  always #10 clk_i = ~clk_i;  // 50 MHz

  wide_slot_asm dut_i (.*);

  typedef struct packed {
    logic [7:0]  op;
    logic [3:0]  dst;
    logic [3:0]  src;
    logic [15:0] off;
    logic [31:0] imm;
    logic        wide;
    logic        ill;
    logic [63:0] imm64;
  } exp_t;

  int n_chk = 0, n_fail = 0, cyc = 0;
  logic [64:0] in_q[$];  // {last, slot}
  exp_t exp_q[$];
  bit m_wait = 0, tr_exp = 0, stall_prev = 0;
  logic [63:0] m_held;
  exp_t saved;
  logic [15:0] lf = 16'hACE1;

  task automatic chk(string req, string what, logic [159:0] act, logic [159:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  function automatic exp_t split(logic [63:0] s);
    exp_t e;
    e.imm = s[63:32]; e.off = s[31:16]; e.src = s[15:12]; e.dst = s[11:8]; e.op = s[7:0];
    e.wide = 1'b0; e.ill = 1'b0; e.imm64 = '0;
    return e;
  endfunction

  function automatic exp_t actual();
    exp_t a;
    a.op = ins_opcode_o; a.dst = ins_dst_o; a.src = ins_src_o; a.off = ins_off_o;
    a.imm = ins_imm_o; a.wide = ins_wide_o; a.ill = ins_illegal_o; a.imm64 = ins_imm64_o;
    return a;
  endfunction

  // bench model of an accepted slot
  task automatic model_push(logic [64:0] s);
    exp_t e;
    if (m_wait) begin
      e = split(m_held); e.wide = 1'b1; e.imm64 = s[63:0];
      exp_q.push_back(e); m_wait = 0;
    end else if (s[7:0] == 8'h18) begin
      if (s[64]) tr_exp = 1;
      else begin m_wait = 1; m_held = s[63:0]; end
    end else begin
      e = split(s[63:0]); e.ill = (s[7:5] == 3'b000);
      exp_q.push_back(e);
    end
  endtask

  task automatic step(bit gaps);
    bit exp_tr;
    @(negedge clk_i);
    cyc++;
    lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
    slot_valid_i = (in_q.size() > 0) && (!gaps || lf[0] || lf[7]);
    slot_data_i  = (in_q.size() > 0) ? in_q[0][63:0] : '0;
    slot_last_i  = (in_q.size() > 0) ? in_q[0][64] : 1'b0;
    ins_ready_i  = !gaps || lf[3] || lf[9];
    #5;
    exp_tr = tr_exp; tr_exp = 0;
    if (exp_tr || trunc_err_o !== 1'b0) chk("R5", "trunc pulse", trunc_err_o, exp_tr);
    if (stall_prev) begin
      chk("R6", "valid held", ins_valid_o, 1'b1);
      chk("R6", "fields stable", actual(), saved);
    end
    stall_prev = 0;
    if (ins_valid_o && !ins_ready_i) begin
      chk("R6", "slot_ready low", slot_ready_o, 1'b0);
      saved = actual(); stall_prev = 1;
    end
    if (ins_valid_o && ins_ready_i) begin
      if (exp_q.size() == 0) chk("R7", "extra output", actual(), '0);
      else begin
        exp_t e = exp_q.pop_front();
        chk(e.wide ? "R2" : (e.ill ? "R4" : "R1/R3"), "instruction", actual(), e);
      end
    end
    if (slot_valid_i && slot_ready_o) model_push(in_q.pop_front());
  endtask

  task automatic run(bit gaps);
    while ((in_q.size() > 0 || exp_q.size() > 0) && cyc < 50000) step(gaps);
    for (int k = 0; k < 3; k++) step(gaps);
    if (cyc >= 50000) begin
      n_chk++; n_fail++;
      $display("FAIL R7 watchdog act=%0d exp=%0d", cyc, 50000);
      in_q.delete(); exp_q.delete();
    end
  endtask

  task automatic load_sweep();
    for (int op = 0; op < 256; op++) begin
      logic [7:0] o = op[7:0];
      logic [31:0] imm = (32'(op) * 32'h01010101) ^ 32'hA5000000;
      in_q.push_back({1'b0, imm, o, ~o, o[3:0], o[7:4], o});
      if (o == 8'h18) in_q.push_back({1'b0, 64'hF0E1D2C3B4A59687 ^ 64'(op)});
    end
  endtask

  initial begin
    // R8: reset state
    repeat (3) @(negedge clk_i);
    #5;
    chk("R8", "valid in reset", ins_valid_o, 1'b0);
    chk("R8", "trunc in reset", trunc_err_o, 1'b0);
    @(negedge clk_i) rst_ni = 1'b1;

    // full opcode sweep, no stalls, then with gaps and backpressure
    load_sweep(); run(0);
    load_sweep(); run(1);

    // R5: truncation cases, back to back, and a pair whose second slot is last
    in_q.push_back({1'b1, 32'h11112222, 16'h3344, 8'h56, 8'h18});
    in_q.push_back({1'b1, 32'h55556666, 16'h7788, 8'h9A, 8'h18});
    in_q.push_back({1'b0, 32'h0BADF00D, 16'h0042, 8'h21, 8'h18});
    in_q.push_back({1'b1, 64'h0123456789ABCDEF});
    in_q.push_back({1'b0, 32'hCAFE0000, 16'h0008, 8'h12, 8'h61});
    run(0);
    in_q.push_back({1'b1, 32'h1, 16'h2, 8'h34, 8'h18});
    in_q.push_back({1'b0, 32'h7, 16'h9, 8'h43, 8'h61});
    run(1);

    // R8: reset drops a half-received wide instruction
    in_q.push_back({1'b0, 32'hAAAA5555, 16'h1234, 8'h77, 8'h18});
    run(0);
    @(negedge clk_i) rst_ni = 1'b0;
    m_wait = 0; stall_prev = 0; tr_exp = 0;
    @(negedge clk_i) rst_ni = 1'b1;
    #5 chk("R8", "valid after reset", ins_valid_o, 1'b0);
    in_q.push_back({1'b0, 32'h00C0FFEE, 16'hFFFE, 8'h3C, 8'h61});
    run(0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule